// File: doc/BRIEF.md
# Closed-Caption Line Capture Controller

This block picks closed-caption bytes out of the vertical-blanking interval and holds them for a host. An upstream slicer delivers the caption line as a serial stream of recovered bits, one bit for each accepted valid/ready transfer. The block also receives the current field parity, the line number, a video-standard selector and a two-bit capture mode. When the current line is the caption line of an enabled field, the block gathers the bits in a shift register. Once a full word is present, it moves the word into that field's pair of byte registers and raises that field's read-status flag.

The host reads the bytes through a simple read port with one cycle of latency. Reading a field's second byte clears that field's flag. The bit stream uses valid/ready, but the block never applies back-pressure. `bit_ready` is low while reset is asserted and high at all other times. Bits offered on lines that are not selected, or after a word is already complete, are accepted and discarded. A bit is taken only on a cycle where both `bit_valid` and `bit_ready` are high.

Top module: `cc_line_capture`

## Requirements
- R1: After reset both status flags are 0, all four byte registers read 0, and `rd_data` is 0.
- R2: With `cap_mode` = 0 (both fields disabled), no status flag is set and no byte register changes, whatever bits arrive.
- R3: With `std_sel` = 0, the odd field (`field_odd` = 1) captures on line 21 and the even field captures on line 284. Bits on any other line are ignored.
- R4: With `std_sel` = 1, the capture lines are 18 (odd) and 281 (even). With `std_sel` = 2, they are 22 (odd) and 335 (even). With `std_sel` = 3, no line captures.
- R5: A word is 16 bits, least significant bit first. Bits 0..7 go to byte A and bits 8..15 go to byte B. The odd field's A and B bytes are at addresses 0x20 and 0x21. The even field's A and B bytes are at 0x22 and 0x23.
- R6: In the clock edge that accepts the 16th bit, the word moves into the field's byte registers and the field's status flag (`stat_odd` or `stat_even`) becomes 1.
- R7: A read of address 0x21 clears `stat_odd` and a read of 0x23 clears `stat_even`. Reading an A byte clears no flag.
- R8: If a transfer and the clearing read of the same field fall in the same cycle, the flag stays 1. The read returns the B byte as it was before the transfer.
- R9: `cap_mode` bit 0 enables the odd field and bit 1 enables the even field. A field whose bit is 0 ignores its line and its flag never rises.
- R10: If `line_end` pulses before 16 bits have arrived, the partial bits are discarded and nothing is transferred. The next line starts from an empty word.
- R11: Bits that arrive after the 16th bit and before `line_end` are ignored.
- R12: `rd_data` updates on the clock edge after a cycle with `rd_en` high. Addresses outside 0x20..0x23 return 0.
- R13: `bit_ready` is 1 whenever reset is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_odd | input | 1 | 1 during the odd field, 0 during the even field |
| line_num | input | 11 | Current line number |
| std_sel | input | 2 | 0 NTSC, 1 PAL lines 18/281, 2 PAL lines 22/335, 3 none |
| cap_mode | input | 2 | Bit 0 enables odd-field capture, bit 1 enables even-field capture |
| bit_valid | input | 1 | A caption bit is offered |
| bit_data | input | 1 | Caption bit value |
| bit_ready | output | 1 | Block accepts a bit (always 1 out of reset) |
| line_end | input | 1 | One-cycle pulse at the end of each line |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Read data, valid one cycle after `rd_en` |
| stat_odd | output | 1 | Odd-field read-status flag |
| stat_even | output | 1 | Even-field read-status flag |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, which give a 16-bit word, 11-bit line numbers, and the standard line numbers for all three standards. This lets it walk every standard, every capture mode and both field parities on lines that sit next to the capture lines. The 16-bit word length makes it practical to drive short lines, over-long lines, and a 16th bit that lands in the same cycle as the clearing read.

// File: rtl/cc_cap_pkg.sv
package cc_cap_pkg;
  typedef enum logic [1:0] {
    STD_NTSC  = 2'd0,
    STD_PAL_A = 2'd1,
    STD_PAL_B = 2'd2,
    STD_NONE  = 2'd3
  } vid_std_e;

  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned FIELD_NUM  = 2;
  localparam logic [ADDR_W-1:0] BASE_ADDR = 8'h20;
endpackage

// File: rtl/cc_line_match.sv
module cc_line_match #(
  parameter int unsigned LINE_W     = 11,
  parameter int unsigned NTSC_ODD   = 21,
  parameter int unsigned NTSC_EVEN  = 284,
  parameter int unsigned PALA_ODD   = 18,
  parameter int unsigned PALA_EVEN  = 281,
  parameter int unsigned PALB_ODD   = 22,
  parameter int unsigned PALB_EVEN  = 335
) (
  input  logic              field_odd,
  input  logic [LINE_W-1:0] line_num,
  input  logic [1:0]        std_sel,
  input  logic [1:0]        cap_mode,
  output logic              active
);
  import cc_cap_pkg::*;

  logic [LINE_W-1:0] target;
  logic              std_ok;
  logic              fld_en;

  always_comb begin
    std_ok = 1'b1;
    target = '0;
    unique case (vid_std_e'(std_sel))
      STD_NTSC:  target = field_odd ? LINE_W'(NTSC_ODD) : LINE_W'(NTSC_EVEN);
      STD_PAL_A: target = field_odd ? LINE_W'(PALA_ODD) : LINE_W'(PALA_EVEN);
      STD_PAL_B: target = field_odd ? LINE_W'(PALB_ODD) : LINE_W'(PALB_EVEN);
      default:   std_ok = 1'b0;
    endcase
    fld_en = field_odd ? cap_mode[0] : cap_mode[1];
    active = std_ok && fld_en && (line_num == target);
  end
endmodule

// File: rtl/cc_deser.sv
module cc_deser #(
  parameter int unsigned DATA_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic                 bit_take,
  input  logic                 bit_data,
  input  logic                 line_end,
  output logic                 done,
  output logic [DATA_BITS-1:0] word
);
  localparam int unsigned CNT_W = $clog2(DATA_BITS + 1);

  logic [CNT_W-1:0]     count;
  logic [DATA_BITS-2:0] shreg;
  logic                 take;

  assign take = active && bit_take && !line_end && (count < CNT_W'(DATA_BITS));
  assign done = take && (count == CNT_W'(DATA_BITS - 1));
  assign word = {bit_data, shreg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (line_end || !active) begin
      count <= '0;
    end else if (take) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
    end else begin
      for (int i = 0; i < DATA_BITS - 1; i++) begin
        if (take && count == CNT_W'(i)) shreg[i] <= bit_data;
      end
    end
  end
endmodule

// File: rtl/cc_field_bank.sv
module cc_field_bank #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xfer,
  input  logic [2*BYTE_W-1:0]   word,
  input  logic                  clr,
  output logic [BYTE_W-1:0]     byte_a,
  output logic [BYTE_W-1:0]     byte_b,
  output logic                  flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_a <= '0;
      byte_b <= '0;
    end else if (xfer) begin
      byte_a <= word[BYTE_W-1:0];
      byte_b <= word[2*BYTE_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (xfer)   flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end
endmodule

// File: rtl/cc_line_capture.sv
module cc_line_capture #(
  parameter int unsigned LINE_W = 11,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] line_num,
  input  logic [1:0]        std_sel,
  input  logic [1:0]        cap_mode,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  input  logic              line_end,
  input  logic              rd_en,
  input  logic [7:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              stat_odd,
  output logic              stat_even
);
  import cc_cap_pkg::*;

  localparam int unsigned DATA_BITS = 2 * BYTE_W;

  logic                 active;
  logic                 done;
  logic [DATA_BITS-1:0] word;
  logic                 ready_q;
  logic [FIELD_NUM-1:0] xfer;
  logic [FIELD_NUM-1:0] flags;
  logic [BYTE_W-1:0]    bank_a [FIELD_NUM];
  logic [BYTE_W-1:0]    bank_b [FIELD_NUM];
  logic [BYTE_W-1:0]    rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign bit_ready = ready_q;

  cc_line_match #(.LINE_W(LINE_W)) u_match (
    .field_odd (field_odd),
    .line_num  (line_num),
    .std_sel   (std_sel),
    .cap_mode  (cap_mode),
    .active    (active)
  );

  cc_deser #(.DATA_BITS(DATA_BITS)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .bit_take (bit_valid && ready_q),
    .bit_data (bit_data),
    .line_end (line_end),
    .done     (done),
    .word     (word)
  );

  // bank 0 holds the odd field, bank 1 the even field
  for (genvar g = 0; g < FIELD_NUM; g++) begin : g_bank
    localparam logic [7:0] B_ADDR = BASE_ADDR + 8'(2 * g + 1);
    logic fld_match;
    assign fld_match = (g == 0) ? field_odd : !field_odd;
    assign xfer[g]   = done && fld_match;

    cc_field_bank #(.BYTE_W(BYTE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .xfer   (xfer[g]),
      .word   (word),
      .clr    (rd_en && rd_addr == B_ADDR),
      .byte_a (bank_a[g]),
      .byte_b (bank_b[g]),
      .flag   (flags[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int f = 0; f < FIELD_NUM; f++) begin
      if (rd_addr == BASE_ADDR + 8'(2 * f))     rd_mux = bank_a[f];
      if (rd_addr == BASE_ADDR + 8'(2 * f + 1)) rd_mux = bank_b[f];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign stat_odd  = flags[0];
  assign stat_even = flags[1];
endmodule

// File: rtl/cc_line_capture_chk.sv
module cc_line_capture_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              field_odd,
  input logic [1:0]        cap_mode,
  input logic              bit_ready,
  input logic              rd_en,
  input logic [7:0]        rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic              stat_odd,
  input logic              stat_even,
  input logic              xfer_odd,
  input logic              xfer_even
);
  // R2 and R9: a flag rises only if its field was enabled and active
  p_odd_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_odd) |-> $past(cap_mode[0] && field_odd));
  p_even_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_even) |-> $past(cap_mode[1] && !field_odd));
  p_off_no_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 2'd0) |-> !(xfer_odd || xfer_even));
  // R6 and R8: a transfer always leaves the flag set
  p_set_wins_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_odd |=> stat_odd);
  p_set_wins_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_even |=> stat_even);
  // R7: a flag falls only after a read of its B byte
  p_odd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_odd) |-> $past(rd_en && rd_addr == 8'h21));
  p_even_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_even) |-> $past(rd_en && rd_addr == 8'h23));
  // R12: unmapped reads return zero
  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr < 8'h20 || rd_addr > 8'h23)) |=> (rd_data == '0));
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R13
  p_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> bit_ready);
endmodule

bind cc_line_capture cc_line_capture_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .field_odd (field_odd),
  .cap_mode  (cap_mode),
  .bit_ready (bit_ready),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .stat_odd  (stat_odd),
  .stat_even (stat_even),
  .xfer_odd  (xfer[0]),
  .xfer_even (xfer[1])
);

// File: tb/cc_line_capture_test.sv
module cc_line_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        field_odd = 1'b1;
  logic [10:0] line_num = '0;
  logic [1:0]  std_sel = 2'd0;
  logic [1:0]  cap_mode = 2'd3;
  logic        bit_valid = 1'b0;
  logic        bit_data = 1'b0;
  logic        bit_ready;
  logic        line_end = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        stat_odd, stat_even;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cc_line_capture uut (
    .clk(clk), .rst_n(rst_n), .field_odd(field_odd), .line_num(line_num),
    .std_sel(std_sel), .cap_mode(cap_mode), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .line_end(line_end),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .stat_odd(stat_odd), .stat_even(stat_even)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_line(bit odd, int line, logic [31:0] w, int n);
    field_odd = odd;
    line_num  = 11'(line);
    for (int i = 0; i < n; i++) begin
      bit_valid = 1'b1;
      bit_data  = w[i];
      @(negedge clk);
    end
    bit_valid = 1'b0;
    line_end  = 1'b1;
    @(negedge clk);
    line_end  = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic chk_field(string req, bit odd, logic [15:0] w);
    logic [7:0] v;
    logic [7:0] base;
    base = odd ? 8'h20 : 8'h22;
    chk({req, " flag"}, odd ? stat_odd : stat_even, 1);
    rd(base, v);
    chk({req, " byte A"}, v, w[7:0]);
    chk({req, " flag kept after A read (R7)"}, odd ? stat_odd : stat_even, 1);
    rd(base + 8'd1, v);
    chk({req, " byte B"}, v, w[15:8]);
    chk({req, " flag cleared by B read (R7)"}, odd ? stat_odd : stat_even, 0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 stat_odd", stat_odd, 0);
    chk("R1 stat_even", stat_even, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R13 bit_ready", bit_ready, 1);
    for (int a = 8'h20; a <= 8'h23; a++) begin
      rd(8'(a), v);
      chk("R1 byte reg", v, 0);
    end
  endtask

  task automatic t_ntsc;
    std_sel = 2'd0; cap_mode = 2'd3;
    send_line(1, 21, 32'hA53C, 16);
    chk_field("R3 R5 R6 odd line 21", 1, 16'hA53C);
    send_line(0, 284, 32'h1234, 16);
    chk_field("R3 R5 R6 even line 284", 0, 16'h1234);
    send_line(1, 22, 32'hFFFF, 16);
    send_line(0, 283, 32'hFFFF, 16);
    chk("R3 odd wrong line", stat_odd, 0);
    chk("R3 even wrong line", stat_even, 0);
  endtask

  task automatic t_pal;
    cap_mode = 2'd3;
    std_sel = 2'd1;
    send_line(1, 18, 32'h5A81, 16);
    chk_field("R4 PAL-A odd 18", 1, 16'h5A81);
    send_line(0, 281, 32'hC3E7, 16);
    chk_field("R4 PAL-A even 281", 0, 16'hC3E7);
    std_sel = 2'd2;
    send_line(1, 18, 32'hFFFF, 16);
    chk("R4 PAL-B ignores 18", stat_odd, 0);
    send_line(1, 22, 32'h0F0F, 16);
    chk_field("R4 PAL-B odd 22", 1, 16'h0F0F);
    send_line(0, 335, 32'h7E18, 16);
    chk_field("R4 PAL-B even 335", 0, 16'h7E18);
    std_sel = 2'd3;
    send_line(1, 21, 32'hFFFF, 16);
    send_line(0, 284, 32'hFFFF, 16);
    chk("R4 std 3 odd", stat_odd, 0);
    chk("R4 std 3 even", stat_even, 0);
    std_sel = 2'd0;
  endtask

  task automatic t_modes;
    logic [7:0] v;
    std_sel = 2'd0;
    cap_mode = 2'd0;
    send_line(1, 21, 32'h9999, 16);
    send_line(0, 284, 32'h8888, 16);
    chk("R2 off odd flag", stat_odd, 0);
    chk("R2 off even flag", stat_even, 0);
    rd(8'h21, v); chk("R2 odd B unchanged", v, 8'h0F);
    rd(8'h22, v); chk("R2 even A unchanged", v, 8'h18);
    cap_mode = 2'd1;
    send_line(0, 284, 32'h4444, 16);
    chk("R9 odd-only ignores even", stat_even, 0);
    rd(8'h23, v); chk("R9 even B unchanged", v, 8'h7E);
    send_line(1, 21, 32'h6655, 16);
    chk_field("R9 odd-only captures odd", 1, 16'h6655);
    cap_mode = 2'd2;
    send_line(1, 21, 32'h3333, 16);
    chk("R9 even-only ignores odd", stat_odd, 0);
    rd(8'h20, v); chk("R9 odd A unchanged", v, 8'h55);
    send_line(0, 284, 32'hBEEF, 16);
    chk_field("R9 even-only captures even", 0, 16'hBEEF);
    cap_mode = 2'd3;
  endtask

  task automatic t_partial;
    logic [7:0] v;
    send_line(1, 21, 32'h03FF, 10);
    chk("R10 no flag on short line", stat_odd, 0);
    rd(8'h20, v); chk("R10 A unchanged", v, 8'h55);
    send_line(1, 21, 32'h2468, 16);
    chk_field("R10 next line starts empty", 1, 16'h2468);
  endtask

  task automatic t_extra;
    send_line(1, 21, 32'h000F_1357, 20);
    chk_field("R11 extra bits ignored", 1, 16'h1357);
  endtask

  task automatic t_set_wins;
    logic [15:0] w2;
    w2 = 16'hC001;
    send_line(1, 21, 32'hABCD, 16);
    field_odd = 1'b1;
    line_num  = 11'd21;
    for (int i = 0; i < 15; i++) begin
      bit_valid = 1'b1; bit_data = w2[i];
      @(negedge clk);
    end
    bit_data = w2[15];
    rd_en = 1'b1; rd_addr = 8'h21;
    @(negedge clk);
    bit_valid = 1'b0; rd_en = 1'b0;
    chk("R8 read returns old B", rd_data, 8'hAB);
    chk("R8 flag stays set", stat_odd, 1);
    line_end = 1'b1;
    @(negedge clk);
    line_end = 1'b0;
    chk_field("R8 new word stored", 1, w2);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    rd(8'h21, v);
    rd(8'h24, v); chk("R12 addr 24 reads 0", v, 0);
    rd(8'h1F, v); chk("R12 addr 1F reads 0", v, 0);
    rd(8'h22, v); chk("R12 one-cycle read", v, 8'hEF);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ntsc;
    t_pal;
    t_modes;
    t_partial;
    t_extra;
    t_set_wins;
    t_unmapped;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule